// File: doc/BRIEF.md
# Bit-Masked Read-Modify-Write Memory

This block is a single-clock memory that offers a write with a per-bit mask, even though its storage array can only replace whole words. A masked write is split into two pipelined cycles. In the first cycle the block captures the request and reads the addressed word. In the second cycle it builds the new word and writes it back. To build the new word, each bit passes through its own 2:1 selector: a selected bit takes the incoming data bit, and an unselected bit keeps the stored value.

A second, independent address port gives registered reads. Two hazards are forwarded:

- **Back-to-back writes to one address.** When a write targets the address whose write-back is happening in the same cycle, it builds on the pending merged word.
- **Read of the word being written.** When a read hits the word being written back, it returns the merged value (write-first).

Write requests may arrive on every clock. A synchronous reset flushes the pipeline and leaves the stored words as they are.

Top module: `bit_mask_ram`

## Requirements
- R1: A write request is accepted only in a cycle where both `wrSelN` and `wrStbN` are low. With either one high, the memory contents do not change.
- R2: The mask `wrMaskN` is active low, bit for bit. Bit i of the addressed word takes `wrData[i]` when `wrMaskN[i]` is 0 and keeps its old value when `wrMaskN[i]` is 1. Other words are untouched.
- R3: An accepted write with `wrMaskN` all ones leaves the addressed word unchanged.
- R4: `rdData` is registered. After the clock edge that samples `rdAddr`, it shows the word stored at that address. A write accepted at that same edge is not yet included.
- R5: A write accepted at edge k is visible to a read sampled at edge k+1, including a read of the same address (write-first collision).
- R6: Writes accepted on consecutive edges to the same address accumulate. Each one merges onto the result of the one before.
- R7: `rst` is synchronous and active high. It drops any write accepted at the edge before it and any write presented while it is high. It does not alter stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every register |
| rst | input | 1 | Synchronous active-high pipeline flush |
| wrSelN | input | 1 | Write port select, active low |
| wrStbN | input | 1 | Write strobe, active low |
| wrAddr | input | ADDR_W | Masked-write word address |
| wrData | input | DATA_W | Masked-write data |
| wrMaskN | input | DATA_W | Per-bit write mask, 0 = bit is written |
| rdAddr | input | ADDR_W | Read port address |
| rdData | output | DATA_W | Registered read data |

## Verification
The bench builds the block with DATA_W = 8 and ADDR_W = 3, so the array has only eight words. At that size every one of the 256 mask patterns can be applied at every address as an unbroken stream of same-address writes. This exercises the forwarding path on each of the 2048 writes. The read address alternates between the word being written and other words, so same-cycle old-value reads, next-cycle forwarded reads and untouched neighbours are all compared against a bench-side array.

// File: rtl/bit_mask_pkg.sv
package bit_mask_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic captureEn;   // accept a masked write this edge
    logic commitEn;    // write merged word back this edge
    logic fwdMerge;    // new request hits the word being written back
    logic fwdRead;     // read port hits the word being written back
  } strobes_t;
endpackage

// File: rtl/bit_mask_store.sv
module bit_mask_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [DATA_W-1:0] wWord,
  input  logic [ADDR_W-1:0] addrA,
  output logic [DATA_W-1:0] wordA,
  input  logic [ADDR_W-1:0] addrB,
  output logic [DATA_W-1:0] wordB
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // whole-word writes only
  always_ff @(posedge clk) begin
    if (we) cells[wAddr] <= wWord;
  end

  assign wordA = cells[addrA];
  assign wordB = cells[addrB];
endmodule

// File: rtl/bit_mask_ctrl.sv
module bit_mask_ctrl
  import bit_mask_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrSelN,
  input  logic              wrStbN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobes_t          strobes,
  output logic [ADDR_W-1:0] commitAddr
);
  logic              wrReq;
  logic              s1Valid;
  logic [ADDR_W-1:0] s1Addr;

  assign wrReq = !wrSelN && !wrStbN;

  always_ff @(posedge clk) begin
    if (rst) s1Valid <= 1'b0;
    else     s1Valid <= wrReq;
    if (wrReq) s1Addr <= wrAddr;
  end

  always_comb begin
    strobes.captureEn = wrReq;
    strobes.commitEn  = s1Valid && !rst;
    strobes.fwdMerge  = strobes.commitEn && wrReq && (wrAddr == s1Addr);
    strobes.fwdRead   = strobes.commitEn && (rdAddr == s1Addr);
  end

  assign commitAddr = s1Addr;

  AST_COMMIT_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    strobes.commitEn |-> $past(wrReq)); // R1

  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !s1Valid); // R7
endmodule

// File: rtl/bit_mask_dp.sv
module bit_mask_dp
  import bit_mask_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] wrMaskN,
  input  logic [DATA_W-1:0] wrPortWord,
  input  logic [DATA_W-1:0] rdPortWord,
  output logic [DATA_W-1:0] mergedWord,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] selQ;
  logic [DATA_W-1:0] oldWord;

  // stage 1: capture request and current word (forwarded on hazard)
  always_ff @(posedge clk) begin
    if (strobes.captureEn) begin
      dataQ   <= wrData;
      selQ    <= ~wrMaskN;
      oldWord <= strobes.fwdMerge ? mergedWord : wrPortWord;
    end
  end

  // stage 2: one recirculating 2:1 selector per bit
  for (genvar b = 0; b < DATA_W; b++) begin : g_bitMux
    assign mergedWord[b] = selQ[b] ? dataQ[b] : oldWord[b];
  end

  // registered read port, write-first on collision
  always_ff @(posedge clk) begin
    rdData <= strobes.fwdRead ? mergedWord : rdPortWord;
  end

  AST_MASK_KEEPS_OLD: assert property (@(posedge clk) disable iff (rst)
    strobes.commitEn |-> (((mergedWord ^ oldWord) & ~selQ) == '0)); // R2

  AST_IDLE_MASK: assert property (@(posedge clk) disable iff (rst)
    (strobes.commitEn && (selQ == '0)) |-> (mergedWord == oldWord)); // R3

  AST_READ_FORWARD: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.fwdRead) |-> (rdData == $past(mergedWord))); // R5

  AST_MERGE_FORWARD: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.fwdMerge) |-> (oldWord == $past(mergedWord))); // R6
endmodule

// File: rtl/bit_mask_ram.sv
module bit_mask_ram
  import bit_mask_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrSelN,
  input  logic              wrStbN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] wrMaskN,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  strobes_t          strobes;
  logic [ADDR_W-1:0] commitAddr;
  logic [DATA_W-1:0] wrPortWord;
  logic [DATA_W-1:0] rdPortWord;
  logic [DATA_W-1:0] mergedWord;

  bit_mask_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .wrSelN(wrSelN), .wrStbN(wrStbN),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .strobes(strobes), .commitAddr(commitAddr)
  );

  bit_mask_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .wrData(wrData), .wrMaskN(wrMaskN),
    .wrPortWord(wrPortWord), .rdPortWord(rdPortWord),
    .mergedWord(mergedWord), .rdData(rdData)
  );

  bit_mask_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) store_i (
    .clk(clk), .we(strobes.commitEn), .wAddr(commitAddr), .wWord(mergedWord),
    .addrA(wrAddr), .wordA(wrPortWord),
    .addrB(rdAddr), .wordB(rdPortWord)
  );
endmodule

// File: tb/bit_mask_ram_tb_top.sv
`timescale 1ns/1ps
module bit_mask_ram_tb_top;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          wrSelN, wrStbN;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [DW-1:0] wrData, wrMaskN;
  logic [DW-1:0] rdData;

  logic [DW-1:0] refMem [NW];
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bit_mask_ram #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wrSelN(wrSelN), .wrStbN(wrStbN),
    .wrAddr(wrAddr), .wrData(wrData), .wrMaskN(wrMaskN),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  // One clock: drive, model, then compare rdData after the edge.
  task automatic step(input logic sel, input logic stb, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wd, input logic [DW-1:0] mN,
                      input logic [AW-1:0] ra, input logic rstIn,
                      input logic applyRef, input logic doChk, input string tag);
    logic [DW-1:0] exp;
    wrSelN = sel; wrStbN = stb; wrAddr = wa; wrData = wd; wrMaskN = mN;
    rdAddr = ra; rst = rstIn;
    exp = refMem[ra];
    if (!sel && !stb && applyRef)
      for (int i = 0; i < DW; i++) if (!mN[i]) refMem[wa][i] = wd[i];
    @(posedge clk);
    @(negedge clk);
    if (doChk) begin
      compared++;
      if (rdData !== exp) begin
        mismatched++;
        $display("FAIL %s: rdData=%h expected %h (rdAddr=%0d)", tag, rdData, exp, ra);
      end
    end
  endtask

  initial begin
    rst = 1'b1; wrSelN = 1'b1; wrStbN = 1'b1;
    wrAddr = '0; wrData = '0; wrMaskN = '1; rdAddr = '0;
    for (int a = 0; a < NW; a++) refMem[a] = '0;
    repeat (3) @(negedge clk);
    // fill array with full-mask writes
    for (int a = 0; a < NW; a++)
      step(1'b0, 1'b0, AW'(a), DW'(a * 37 + 5), '0, AW'(a), 1'b0, 1'b1, 1'b0, "init");
    // reset state: contents survive, all words readable (R4 R7)
    for (int a = 0; a < NW; a++)
      step(1'b1, 1'b1, '0, '0, '1, AW'(a), 1'b0, 1'b1, 1'b1, "R4 R7 reset state");

    // R1: only both-low accepts a write
    step(1'b1, 1'b0, 3'd1, 8'hA5, 8'h00, 3'd1, 1'b0, 1'b1, 1'b1, "R1 sel high");
    step(1'b0, 1'b1, 3'd1, 8'h5A, 8'h00, 3'd1, 1'b0, 1'b1, 1'b1, "R1 strobe high");
    step(1'b1, 1'b1, 3'd1, 8'h33, 8'h00, 3'd1, 1'b0, 1'b1, 1'b1, "R1 both high");
    step(1'b1, 1'b1, '0, '0, '1, 3'd1, 1'b0, 1'b1, 1'b1, "R1 after idle");

    // R3: all-ones mask keeps the word, back to back
    step(1'b0, 1'b0, 3'd4, 8'hFF, 8'hFF, 3'd4, 1'b0, 1'b1, 1'b1, "R3 idle mask");
    step(1'b0, 1'b0, 3'd4, 8'h00, 8'hFF, 3'd4, 1'b0, 1'b1, 1'b1, "R3 idle mask");
    step(1'b1, 1'b1, '0, '0, '1, 3'd4, 1'b0, 1'b1, 1'b1, "R3 idle mask read");

    // R7: reset drops a write accepted the edge before it
    step(1'b0, 1'b0, 3'd2, 8'hFF, 8'h00, 3'd6, 1'b0, 1'b0, 1'b1, "R7 pre");
    step(1'b1, 1'b1, '0, '0, '1, 3'd2, 1'b1, 1'b1, 1'b1, "R7 squash");
    step(1'b1, 1'b1, '0, '0, '1, 3'd2, 1'b0, 1'b1, 1'b1, "R7 squash read");
    // R7: write presented during reset is dropped
    step(1'b0, 1'b0, 3'd3, 8'h00, 8'h00, 3'd3, 1'b1, 1'b0, 1'b1, "R7 write in reset");
    step(1'b1, 1'b1, '0, '0, '1, 3'd3, 1'b0, 1'b1, 1'b1, "R7 write in reset read");
    step(1'b1, 1'b1, '0, '0, '1, 3'd3, 1'b0, 1'b1, 1'b1, "R7 write in reset read");

    // R5: write then immediate read of the same word, single writes
    step(1'b0, 1'b0, 3'd5, 8'hC3, 8'h0F, 3'd5, 1'b0, 1'b1, 1'b1, "R4 same-edge old");
    step(1'b1, 1'b1, '0, '0, '1, 3'd5, 1'b0, 1'b1, 1'b1, "R5 next-edge new");

    // R2 R6 R5 R4: every mask at every address, same-address back to back
    for (int a = 0; a < NW; a++)
      for (int m = 0; m < 256; m++)
        step(1'b0, 1'b0, AW'(a), DW'((a * 29 + m * 113 + 7) ^ (m >> 1)), DW'(m),
             (m % 3 == 0) ? AW'(a) : AW'(a + m), 1'b0, 1'b1, 1'b1, "R2 R5 R6 sweep");

    // final readout of all words (R2 R6)
    for (int a = 0; a < NW; a++)
      step(1'b1, 1'b1, '0, '0, '1, AW'(a), 1'b0, 1'b1, 1'b1, "R2 R6 final");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule